// File: doc/BRIEF.md
# Tag Match Table with Replacement Hint

This block is a small associative lookup table of sixteen slots. Each slot holds a 32-bit tag, four state bits and a valid flag. A lookup request presents a key. The key is compared with every valid slot in the same cycle. One cycle later the block returns a 32-bit result word with a strobe. The word carries a hit flag, a slot number and the slot's state bits, placed in bits 11 down to 3. Every other bit of the word is zero.

When no slot matches, the slot number in the result is the slot used longest ago. Software or a controller can use that slot as the one to replace. The block keeps an ordered recency list of all sixteen slots for this purpose. A hit on a slot, or a write into it, moves that slot to the most recent end of the list.

A separate write port loads a tag and state into a named slot and marks the slot valid. The write can happen in the same cycle as a lookup.

Top module: `cam_lru_hint`

## Requirements
- R1: After reset, `res_valid` is 0, `res_word` is 0 and all sixteen slots are invalid.
- R2: `res_valid` is 1 exactly in the cycle after a cycle with `lk_req` high. It is 0 in every other cycle.
- R3: In every valid result, bits [31:12] and [2:0] of `res_word` are zero.
- R4: On a hit, bit 7 of `res_word` is 1, bits [6:3] hold the matching slot number and bits [11:8] hold that slot's stored state.
- R5: On a miss, bit 7 is 0, bits [11:8] are 0000 and bits [6:3] hold the least recently used slot.
- R6: A slot that has never been written never produces a hit, whatever its stored tag.
- R7: When several valid slots hold the key, the lowest-numbered of them is reported.
- R8: A lookup hit and a write each make the touched slot the most recently used. A miss leaves the recency order unchanged.
- R9: After reset, the recency order runs from slot 0 as least recent up to slot 15 as most recent.
- R10: A write stores its tag and state in slot `wr_idx` and marks the slot valid. Rewriting a slot replaces its old tag, so the old tag no longer hits there.
- R11: A lookup and a write in the same cycle behave as follows. The lookup compares against the contents before the write. The recency list applies the lookup hit first and the write second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_key | input | 32 | Key to look up |
| wr_en | input | 1 | Write a slot |
| wr_idx | input | 4 | Slot to write |
| wr_tag | input | 32 | Tag to store |
| wr_state | input | 4 | State bits to store |
| res_valid | output | 1 | Result strobe, one cycle after `lk_req` |
| res_word | output | 32 | Packed lookup result |

## Verification
The bench goes after the following corner cases:
- **Reset contents.** A lookup of key zero is made right after reset. A design that ignored the valid flags would report a hit on a slot that holds reset-time data.
- **Duplicate tags.** One tag is written into two slots. A design with a reversed priority encoder would report the higher-numbered slot.
- **Misses and recency.** Back-to-back misses are run. A design that touched the recency list on a miss would move the replacement hint on every miss.
- **Same-cycle lookup and write.** A lookup and a write to the same slot are issued together. A design that forwarded the write would hit on the new tag instead of the old one. A design that applied the two recency touches in the wrong order would later name the wrong slot on a miss.
- **Random traffic.** A long run of random traffic over a small key pool is checked against a timestamp model of recency. This exercises multiple matches and varied replacement hints.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int WORD_W  = 32;
  localparam int IDX_LSB = 3;
  localparam int HIT_BIT = 7;
  localparam int ST_LSB  = 8;

  // Place state, hit flag and slot number into a word, other bits zero
  function automatic logic [WORD_W-1:0] pack_result(input logic hit,
                                                    input logic [3:0] idx,
                                                    input logic [3:0] st);
    logic [WORD_W-1:0] w;
    w = '0;
    w[IDX_LSB +: 4] = idx;
    w[HIT_BIT]      = hit;
    w[ST_LSB +: 4]  = hit ? st : 4'd0;
    return w;
  endfunction
endpackage

// File: rtl/cam_match.sv
module cam_match #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [TAG_W-1:0]              key,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);
  logic [ENTRIES-1:0] match_vec;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = valid[g] && (tags[g] == key);
    end
  endgenerate

  // Lowest index wins: scan from the top so lower slots overwrite
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |match_vec;
endmodule

// File: rtl/cam_recency.sv
module cam_recency #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_a_en,
  input  logic [IDX_W-1:0] touch_a_idx,
  input  logic             touch_b_en,
  input  logic [IDX_W-1:0] touch_b_idx,
  output logic [IDX_W-1:0] lru_idx
);
  typedef logic [ENTRIES-1:0][IDX_W-1:0] order_t;

  // Position 0 is least recent, position ENTRIES-1 most recent
  order_t order_q, order_a, order_b;

  function automatic order_t touch(input order_t in, input logic [IDX_W-1:0] e);
    order_t o;
    logic found;
    o = in;
    found = 1'b0;
    for (int i = 0; i < ENTRIES - 1; i++) begin
      if (in[i] == e) found = 1'b1;
      if (found) o[i] = in[i+1];
    end
    o[ENTRIES-1] = e;
    return o;
  endfunction

  always_comb begin
    order_a = touch_a_en ? touch(order_q, touch_a_idx) : order_q;
    order_b = touch_b_en ? touch(order_a, touch_b_idx) : order_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) order_q[i] <= IDX_W'(i);
    end else begin
      order_q <= order_b;
    end
  end

  assign lru_idx = order_q[0];

  // Every slot appears in the list exactly once
  logic [ENTRIES-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < ENTRIES; i++) seen[order_q[i]] = 1'b1;
  end

  // R8
  order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) &seen);

  // R8
  wr_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_b_en |=> order_q[ENTRIES-1] == $past(touch_b_idx));

  // R11
  hit_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_a_en && !touch_b_en) |=> order_q[ENTRIES-1] == $past(touch_a_idx));
endmodule

// File: rtl/cam_lru_hint.sv
module cam_lru_hint #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 32,
  parameter int STATE_W = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [TAG_W-1:0] lk_key,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [STATE_W-1:0] wr_state,
  output logic             res_valid,
  output logic [31:0]      res_word
);
  import cam_pkg::*;

  logic [ENTRIES-1:0][TAG_W-1:0]   tag_q;
  logic [ENTRIES-1:0][STATE_W-1:0] state_q;
  logic [ENTRIES-1:0]              valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]   <= wr_tag;
      state_q[wr_idx] <= wr_state;
    end
  end

  logic             match_hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] lru_idx;

  cam_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
    .tags(tag_q), .valid(valid_q), .key(lk_key),
    .hit(match_hit), .hit_idx(hit_idx)
  );

  // Named events for the assertions
  logic lk_hit, lk_miss;
  assign lk_hit  = lk_req && match_hit;
  assign lk_miss = lk_req && !match_hit;

  cam_recency #(.ENTRIES(ENTRIES)) u_rec (
    .clk(clk), .rst_n(rst_n),
    .touch_a_en(lk_hit), .touch_a_idx(hit_idx),
    .touch_b_en(wr_en),  .touch_b_idx(wr_idx),
    .lru_idx(lru_idx)
  );

  logic [IDX_W-1:0]   sel_idx;
  logic [STATE_W-1:0] sel_state;
  assign sel_idx   = match_hit ? hit_idx : lru_idx;
  assign sel_state = match_hit ? state_q[hit_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
    end else begin
      res_valid <= lk_req;
      if (lk_req) res_word <= pack_result(match_hit, 4'(sel_idx), 4'(sel_state));
    end
  end

  // R2
  res_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> res_valid);

  // R2
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !res_valid);

  // R3
  res_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_word[31:12] == '0 && res_word[2:0] == '0));

  // R5
  miss_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_word[HIT_BIT]) |-> res_word[11:8] == '0);

  // R6
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_word[HIT_BIT]) |-> valid_q[res_word[6:3]]);

  // R4
  hit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid_q[hit_idx] && tag_q[hit_idx] == lk_key));
endmodule

// File: tb/cam_lru_hint_tb.sv
module cam_lru_hint_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_key = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_tag = '0;
  logic [3:0]  wr_state = '0;
  logic        res_valid;
  logic [31:0] res_word;

  always #4 clk = ~clk;

  cam_lru_hint u_dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_key(lk_key),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_state(wr_state),
    .res_valid(res_valid), .res_word(res_word)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model: timestamps instead of an ordered list
  logic [31:0] m_tag [16];
  logic [3:0]  m_st  [16];
  bit          m_val [16];
  int          m_stamp [16];
  int          tnow = 0;

  logic [31:0] exp_q [$];
  string       req_q [$];

  task automatic op(input bit lk, input logic [31:0] key, input bit we,
                    input logic [3:0] widx, input logic [31:0] wtag,
                    input logic [3:0] wst, input string req);
    bit hit;
    int h, lru;
    @(negedge clk);
    lk_req = lk; lk_key = key; wr_en = we; wr_idx = widx; wr_tag = wtag; wr_state = wst;
    hit = 0; h = 0;
    if (lk) begin
      for (int i = 0; i < 16; i++)
        if (!hit && m_val[i] && m_tag[i] == key) begin hit = 1; h = i; end
      if (hit) exp_q.push_back({20'd0, m_st[h], 1'b1, 4'(h), 3'd0});
      else begin
        lru = 0;
        for (int i = 1; i < 16; i++) if (m_stamp[i] < m_stamp[lru]) lru = i;
        exp_q.push_back({20'd0, 4'd0, 1'b0, 4'(lru), 3'd0});
      end
      req_q.push_back(req);
    end
    if (lk && hit) m_stamp[h] = 2 * tnow;
    if (we) begin
      m_stamp[widx] = 2 * tnow + 1;
      m_tag[widx] = wtag; m_st[widx] = wst; m_val[widx] = 1;
    end
    tnow++;
  endtask

  task automatic idle();
    @(negedge clk);
    lk_req = 0; wr_en = 0;
    tnow++;
  endtask

  // Monitor: pop and compare each result
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && !done && res_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected strobe act=%h exp=none", res_word);
        end else begin
          logic [31:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if (res_word !== e) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", r, res_word, e);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 16; i++) begin
      m_val[i] = 0; m_tag[i] = '0; m_st[i] = '0; m_stamp[i] = 2 * (i - 16);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset outputs
    checks++;
    if (res_valid !== 1'b0 || res_word !== 32'd0) begin
      fails++;
      $display("FAIL R1 act=%b/%h exp=0/0", res_valid, res_word);
    end

    // R1 R6 R9: key 0 misses, hint is slot 0
    op(1, 32'd0, 0, 0, 0, 0, "R6");
    // R8: a miss does not move the hint
    op(1, 32'h1234_5678, 0, 0, 0, 0, "R8");
    idle(); idle();
    // R2: no strobe during idle cycles (checked by the monitor)

    // R10: load all slots in a scattered order
    for (int k = 0; k < 16; k++) begin
      int s;
      s = (k * 7) % 16;
      op(0, 0, 1, 4'(s), 32'hA000_0000 + s * 32'h111, 4'(s ^ 5), "R10");
    end
    // R4: hits on several slots
    op(1, 32'hA000_0000 + 3 * 32'h111, 0, 0, 0, 0, "R4");
    op(1, 32'hA000_0000 + 15 * 32'h111, 0, 0, 0, 0, "R4");
    op(1, 32'hA000_0000, 0, 0, 0, 0, "R4");
    // R5 R8: misses name the least recent slot
    op(1, 32'hDEAD_BEEF, 0, 0, 0, 0, "R5");
    op(1, 32'hDEAD_BEEF, 0, 0, 0, 0, "R8");
    // R7: duplicate tag in slots 12 and 4
    op(0, 0, 1, 4'd12, 32'hA000_0000 + 4 * 32'h111, 4'hC, "R7");
    op(1, 32'hA000_0000 + 4 * 32'h111, 0, 0, 0, 0, "R7");
    // R11: same-cycle lookup of slot 9 and rewrite of slot 9
    op(1, 32'hA000_0000 + 9 * 32'h111, 1, 4'd9, 32'h5555_0009, 4'h9, "R11");
    // R10: old tag gone, new tag hits
    op(1, 32'hA000_0000 + 9 * 32'h111, 0, 0, 0, 0, "R10");
    op(1, 32'h5555_0009, 0, 0, 0, 0, "R10");
    // R11: lookup hit on slot 2 with a write to slot 6 in the same cycle
    op(1, 32'hA000_0000 + 2 * 32'h111, 1, 4'd6, 32'h6666_0006, 4'h6, "R11");
    op(1, 32'h0BAD_0BAD, 0, 0, 0, 0, "R11");
    // R3: covered by every compare of the full word

    // Random traffic over a small key pool
    r = 32'hACE1_2357;
    for (int n = 0; n < 600; n++) begin
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      op(r[0] | r[1], 32'hC0DE_0000 + (r[12:8] % 24), r[4:2] == 3'd0,
         r[19:16], 32'hC0DE_0000 + (r[24:20] % 24), r[28:25], "R8");
    end
    idle(); idle(); idle();
    done = 1'b1;
    // R2: every request produced exactly one strobe
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 pending act=%0d exp=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule